// File: doc/BRIEF.md
# Transceiver Interrupt Status and Mask

This block gathers four event sources from a line transceiver and presents them to a processor as one maskable interrupt status register. The sources are a line-activity level, a change in the received line state (the INFO code together with a code-violation flag), a change in the received S/Q-channel code word, and a per-multiframe request for new transmit S/Q data. It drives one interrupt output, which is high while any unmasked status bit is set.

Software reaches the block through a small synchronous register bus. The read data depends only on the address, so a plain address lookup has no side effect. Each latched status bit is cleared by its own access when a read or write strobe is given: a read of the receiver-status register, a read of the S/Q receive register, or a write of the S/Q transmit register. The activity bit is not latched and follows the line. A received S/Q code and a loaded transmit code both change only at a multiframe boundary strobe, so software has one whole multiframe to service each of them.

Top module: `tr_irq_top`

## Requirements
- R1: After reset the status register reads 0xF0, the mask register reads 0xFF, the receiver-status, S/Q receive and S/Q transmit registers read 0, `sqTxCode` is 0 and `irq` is low.
- R2: Status bit 3 (activity) equals `lineSig` as sampled at the previous clock edge. It is not latched and drops once the line goes quiet.
- R3: The receiver-status register (address 2) holds `{rxCodeViol, rxInfo}` in bits 4:0, sampled every cycle. Status bit 2 (receiver change) sets on the edge at which the sampled value differs from the held one.
- R4: A read strobe at address 2 clears status bit 2. If a receiver change falls in the same cycle, the bit stays set.
- R5: The S/Q receive register (address 3) loads `sqRxCode` only on a cycle with `mfStrobe` high and otherwise holds its value. Status bit 1 sets when the loaded code differs from the held one.
- R6: A read strobe at address 3 clears status bit 1. A setting event in the same cycle wins.
- R7: Status bit 0 (transmit writable) sets at every `mfStrobe`. A write to address 4 clears it, and a strobe in the same cycle wins.
- R8: The mask register (address 1, bits 3:0) gives one mask bit per status bit at the same position. A 1 disables that bit. `irq` is high exactly when some status bit is set while its mask bit is 0.
- R9: A write to address 4 stores the low 4 bits, which read back at address 4. `sqTxCode` takes the stored value on the edge of each `mfStrobe`.
- R10: Writes to addresses 0, 2, 3 and 5 to 7 change nothing. Reads of addresses 5 to 7 return 0. Status and mask bits 7:4 read as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| lineSig | input | 1 | Receive signal present on the line |
| rxInfo | input | 4 | Received INFO code |
| rxCodeViol | input | 1 | Receive code violation flag |
| sqRxCode | input | 4 | Received S/Q-channel code word |
| mfStrobe | input | 1 | One-cycle multiframe boundary pulse |
| busAddr | input | 3 | Register address |
| busRd | input | 1 | Read strobe; carries the clearing side effects |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for `busAddr`, combinational |
| sqTxCode | output | 4 | S/Q code being transmitted in the current multiframe |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every input is synchronous to `clk`, that `mfStrobe` is a single-cycle pulse, and that `busRd` and `busWr` are never high together. They also assume that the clearing rules are checked only on cycles with no competing setting event. The stimulus keeps to these limits: it drives inputs on the falling edge, pulses the boundary strobe on a fixed period or for one cycle in directed steps, and picks exactly one bus operation (idle, read or write) per cycle. The directed steps force the cases where a clear and a set land in the same cycle.

// File: rtl/tr_irq_pkg.sv
package tr_irq_pkg;

  localparam int NUM_IRQ = 4;

  localparam int BIT_SQW = 0;
  localparam int BIT_SQC = 1;
  localparam int BIT_RXC = 2;
  localparam int BIT_LVL = 3;

  localparam int ADR_STATUS = 0;
  localparam int ADR_MASK   = 1;
  localparam int ADR_RXSTAT = 2;
  localparam int ADR_SQRX   = 3;
  localparam int ADR_SQTX   = 4;

  typedef struct packed {
    logic rdRxStat;
    logic rdSqRx;
    logic wrMask;
    logic wrSqTx;
  } busStrobes_t;

endpackage

// File: rtl/tr_irq_ctrl.sv
module tr_irq_ctrl
  import tr_irq_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  output busStrobes_t       strobes,
  output logic [ADDR_W-1:0] rdSel
);

  always_comb begin
    strobes          = '0;
    strobes.rdRxStat = busRd && (int'(busAddr) == ADR_RXSTAT);
    strobes.rdSqRx   = busRd && (int'(busAddr) == ADR_SQRX);
    strobes.wrMask   = busWr && (int'(busAddr) == ADR_MASK);
    strobes.wrSqTx   = busWr && (int'(busAddr) == ADR_SQTX);
  end

  assign rdSel = busAddr;

endmodule

// File: rtl/tr_irq_datapath.sv
module tr_irq_datapath
  import tr_irq_pkg::*;
#(
  parameter int INFO_W = 4,
  parameter int SQ_W   = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                lineSig,
  input  logic [INFO_W-1:0]   rxInfo,
  input  logic                rxCodeViol,
  input  logic [SQ_W-1:0]     sqRxCode,
  input  logic                mfStrobe,
  input  busStrobes_t         strobes,
  input  logic [ADDR_W-1:0]   rdSel,
  input  logic [DATA_W-1:0]   wrData,
  output logic [DATA_W-1:0]   rdData,
  output logic [SQ_W-1:0]     sqTxCode,
  output logic [NUM_IRQ-1:0]  irqStat,
  output logic [NUM_IRQ-1:0]  maskBits,
  output logic [INFO_W:0]     rxHeld,
  output logic [SQ_W-1:0]     sqHeld,
  output logic                irq
);

  localparam int RXS_W = INFO_W + 1;

  logic              lvlQ;
  logic              rxChg;
  logic              sqChg;
  logic              sqWr;
  logic [SQ_W-1:0]   txReg;
  logic [SQ_W-1:0]   txOut;
  logic [RXS_W-1:0]  rxNow;
  logic              rxSet;
  logic              sqSet;
  logic [NUM_IRQ-1:0] enabled;

  assign rxNow = {rxCodeViol, rxInfo};
  assign rxSet = (rxNow != rxHeld);
  assign sqSet = mfStrobe && (sqRxCode != sqHeld);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlQ   <= 1'b0;
      rxHeld <= '0;
      rxChg  <= 1'b0;
    end else begin
      lvlQ   <= lineSig;
      rxHeld <= rxNow;
      rxChg  <= rxSet || (rxChg && !strobes.rdRxStat);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqHeld <= '0;
      sqChg  <= 1'b0;
    end else begin
      if (mfStrobe) sqHeld <= sqRxCode;
      sqChg <= sqSet || (sqChg && !strobes.rdSqRx);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sqWr  <= 1'b0;
      txReg <= '0;
      txOut <= '0;
    end else begin
      sqWr <= mfStrobe || (sqWr && !strobes.wrSqTx);
      if (strobes.wrSqTx) txReg <= wrData[SQ_W-1:0];
      if (mfStrobe) txOut <= txReg;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskBits <= '1;
    else if (strobes.wrMask) maskBits <= wrData[NUM_IRQ-1:0];
  end

  always_comb begin
    irqStat          = '0;
    irqStat[BIT_LVL] = lvlQ;
    irqStat[BIT_RXC] = rxChg;
    irqStat[BIT_SQC] = sqChg;
    irqStat[BIT_SQW] = sqWr;
  end

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_enable
    assign enabled[g] = irqStat[g] & ~maskBits[g];
  end
  assign irq = |enabled;

  assign sqTxCode = txOut;

  always_comb begin
    rdData = '0;
    case (int'(rdSel))
      ADR_STATUS: begin
        rdData[DATA_W-1:NUM_IRQ] = '1;
        rdData[NUM_IRQ-1:0]      = irqStat;
      end
      ADR_MASK: begin
        rdData[DATA_W-1:NUM_IRQ] = '1;
        rdData[NUM_IRQ-1:0]      = maskBits;
      end
      ADR_RXSTAT: rdData[RXS_W-1:0] = rxHeld;
      ADR_SQRX:   rdData[SQ_W-1:0]  = sqHeld;
      ADR_SQTX:   rdData[SQ_W-1:0]  = txReg;
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/tr_irq_top.sv
module tr_irq_top
  import tr_irq_pkg::*;
#(
  parameter int INFO_W = 4,
  parameter int SQ_W   = 4,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineSig,
  input  logic [INFO_W-1:0] rxInfo,
  input  logic              rxCodeViol,
  input  logic [SQ_W-1:0]   sqRxCode,
  input  logic              mfStrobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic [SQ_W-1:0]   sqTxCode,
  output logic              irq
);

  busStrobes_t        strobes;
  logic [ADDR_W-1:0]  rdSel;
  logic [NUM_IRQ-1:0] irqStat;
  logic [NUM_IRQ-1:0] maskBits;
  logic [INFO_W:0]    rxHeld;
  logic [SQ_W-1:0]    sqHeld;

  tr_irq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .strobes (strobes),
    .rdSel   (rdSel)
  );

  tr_irq_datapath #(
    .INFO_W(INFO_W), .SQ_W(SQ_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .lineSig    (lineSig),
    .rxInfo     (rxInfo),
    .rxCodeViol (rxCodeViol),
    .sqRxCode   (sqRxCode),
    .mfStrobe   (mfStrobe),
    .strobes    (strobes),
    .rdSel      (rdSel),
    .wrData     (busWdata),
    .rdData     (busRdata),
    .sqTxCode   (sqTxCode),
    .irqStat    (irqStat),
    .maskBits   (maskBits),
    .rxHeld     (rxHeld),
    .sqHeld     (sqHeld),
    .irq        (irq)
  );

endmodule

// File: rtl/tr_irq_checker.sv
module tr_irq_checker
  import tr_irq_pkg::*;
#(
  parameter int INFO_W = 4,
  parameter int SQ_W   = 4,
  parameter int ADDR_W = 3
) (
  input logic               clk,
  input logic               rstN,
  input logic               lineSig,
  input logic [INFO_W-1:0]  rxInfo,
  input logic               rxCodeViol,
  input logic               mfStrobe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busRd,
  input logic               busWr,
  input logic               irq,
  input logic [NUM_IRQ-1:0] irqStat,
  input logic [NUM_IRQ-1:0] maskBits,
  input logic [INFO_W:0]    rxHeld,
  input logic [SQ_W-1:0]    sqHeld
);

  assert_lvl_follow_R2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (irqStat[BIT_LVL] == $past(lineSig)));

  assert_rxc_set_R3: assert property (@(posedge clk) disable iff (!rstN)
    ({rxCodeViol, rxInfo} != rxHeld) |=> irqStat[BIT_RXC]);

  assert_rxc_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && int'(busAddr) == ADR_RXSTAT && {rxCodeViol, rxInfo} == rxHeld)
      |=> !irqStat[BIT_RXC]);

  assert_sq_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !mfStrobe |=> $stable(sqHeld));

  assert_sqc_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && int'(busAddr) == ADR_SQRX && !mfStrobe) |=> !irqStat[BIT_SQC]);

  assert_sqw_set_R7: assert property (@(posedge clk) disable iff (!rstN)
    mfStrobe |=> irqStat[BIT_SQW]);

  assert_sqw_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && int'(busAddr) == ADR_SQTX && !mfStrobe) |=> !irqStat[BIT_SQW]);

  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (&maskBits) |-> !irq);

  assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqStat != '0));

endmodule

bind tr_irq_top tr_irq_checker #(
  .INFO_W(INFO_W), .SQ_W(SQ_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .lineSig    (lineSig),
  .rxInfo     (rxInfo),
  .rxCodeViol (rxCodeViol),
  .mfStrobe   (mfStrobe),
  .busAddr    (busAddr),
  .busRd      (busRd),
  .busWr      (busWr),
  .irq        (irq),
  .irqStat    (irqStat),
  .maskBits   (maskBits),
  .rxHeld     (rxHeld),
  .sqHeld     (sqHeld)
);

// File: tb/tr_irq_top_bench.sv
module tr_irq_top_bench;

  localparam int MF_CYC   = 16;
  localparam int RAND_CYC = 3000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineSig = 1'b0;
  logic [3:0] rxInfo = '0;
  logic       rxCodeViol = 1'b0;
  logic [3:0] sqRxCode = '0;
  logic       mfStrobe = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [3:0] sqTxCode;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // expected state, built from the requirements
  logic       mLvl, mRic, mSqc, mSqw;
  logic [4:0] mRx;
  logic [3:0] mSq, mMask, mTx, mTxOut;

  always #4 clk = ~clk;

  tr_irq_top u_tr_irq_top (
    .clk(clk), .rstN(rstN), .lineSig(lineSig), .rxInfo(rxInfo),
    .rxCodeViol(rxCodeViol), .sqRxCode(sqRxCode), .mfStrobe(mfStrobe),
    .busAddr(busAddr), .busRd(busRd), .busWr(busWr), .busWdata(busWdata),
    .busRdata(busRdata), .sqTxCode(sqTxCode), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] modelStat();
    return {mLvl, mRic, mSqc, mSqw};
  endfunction

  function automatic logic [7:0] modelRead(input int a);
    case (a)
      0: return {4'hF, modelStat()};
      1: return {4'hF, mMask};
      2: return {3'b000, mRx};
      3: return {4'h0, mSq};
      4: return {4'h0, mTx};
      default: return 8'h00;
    endcase
  endfunction

  function automatic string readTag(input int a);
    case (a)
      0: return "R2";
      1: return "R8";
      2: return "R3";
      3: return "R5";
      4: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic modelReset();
    mLvl = 0; mRic = 0; mSqc = 0; mSqw = 0;
    mRx = '0; mSq = '0; mMask = 4'hF; mTx = '0; mTxOut = '0;
  endtask

  task automatic modelEdge();
    logic [4:0] rxNow;
    logic rxSet, sqSet;
    rxNow = {rxCodeViol, rxInfo};
    rxSet = (rxNow != mRx);
    sqSet = mfStrobe && (sqRxCode != mSq);
    mLvl = lineSig;
    mRic = rxSet || (mRic && !(busRd && busAddr == 3'd2));
    mRx  = rxNow;
    mSqc = sqSet || (mSqc && !(busRd && busAddr == 3'd3));
    if (mfStrobe) mSq = sqRxCode;
    mSqw = mfStrobe || (mSqw && !(busWr && busAddr == 3'd4));
    if (mfStrobe) mTxOut = mTx;
    if (busWr && busAddr == 3'd4) mTx = busWdata[3:0];
    if (busWr && busAddr == 3'd1) mMask = busWdata[3:0];
  endtask

  // inputs are set by the caller; one clock edge is taken
  task automatic doCycle();
    #1;
    check("R8", irq, |(modelStat() & ~mMask));
    check("R9", sqTxCode, mTxOut);
    if (busRd) check(readTag(busAddr), busRdata, modelRead(busAddr));
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    busRd = 0; busWr = 0; mfStrobe = 0;
  endtask

  task automatic probe(input int a, input string req);
    busAddr = a[2:0];
    #1;
    check(req, busRdata, modelRead(a));
  endtask

  task automatic rdOp(input int a);
    busAddr = a[2:0]; busRd = 1;
    doCycle();
  endtask

  task automatic wrOp(input int a, input logic [7:0] d);
    busAddr = a[2:0]; busWr = 1; busWdata = d;
    doCycle();
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd2913);
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R1 reset values
    #1;
    check("R1", irq, 0);
    check("R1", sqTxCode, 0);
    probe(0, "R1"); check("R1", busRdata, 8'hF0);
    probe(1, "R1"); check("R1", busRdata, 8'hFF);
    probe(2, "R1"); probe(3, "R1"); probe(4, "R1");

    // R2 activity follows the line, not latched
    lineSig = 1; doCycle();
    probe(0, "R2"); check("R2", busRdata, 8'hF8);
    lineSig = 0; doCycle();
    probe(0, "R2"); check("R2", busRdata, 8'hF0);

    // R3 receiver change
    rxInfo = 4'h5; doCycle();
    probe(2, "R3"); check("R3", busRdata, 8'h05);
    probe(0, "R3"); check("R3", busRdata, 8'hF4);
    rxCodeViol = 1; doCycle();
    probe(2, "R3"); check("R3", busRdata, 8'h15);

    // R4 clear on read, set wins when both land together
    rxInfo = 4'h6; rdOp(2);
    probe(0, "R4"); check("R4", busRdata, 8'hF4);
    rdOp(2);
    probe(0, "R4"); check("R4", busRdata, 8'hF0);

    // R5 S/Q receive code updates only at the boundary
    sqRxCode = 4'h9; mfStrobe = 1; doCycle();
    probe(3, "R5"); check("R5", busRdata, 8'h09);
    sqRxCode = 4'h3; doCycle(); doCycle();
    probe(3, "R5"); check("R5", busRdata, 8'h09);
    probe(0, "R5"); check("R5", busRdata, 8'hF3);

    // R6 clear on read of S/Q receive, set wins
    mfStrobe = 1; rdOp(3);
    probe(0, "R6"); check("R6", busRdata[1], 1);
    rdOp(3);
    probe(0, "R6"); check("R6", busRdata[1], 0);

    // R7 writable bit: strobe and write in one cycle, then plain write
    mfStrobe = 1; wrOp(4, 8'h0A);
    probe(0, "R7"); check("R7", busRdata[0], 1);
    wrOp(4, 8'h0A);
    probe(0, "R7"); check("R7", busRdata[0], 0);

    // R9 transmit code loads at the boundary
    probe(4, "R9"); check("R9", busRdata, 8'h0A);
    mfStrobe = 1; doCycle();
    #1 check("R9", sqTxCode, 4'hA);

    // R8 mask gating
    lineSig = 1; doCycle();
    #1 check("R8", irq, 0);
    wrOp(1, 8'hF7);
    #1 check("R8", irq, 1);
    lineSig = 0; doCycle(); doCycle();
    #1 check("R8", irq, 0);
    wrOp(1, 8'hFE);
    #1 check("R8", irq, 1);
    wrOp(1, 8'hFF);
    #1 check("R8", irq, 0);

    // R10 writes to read-only or unmapped addresses ignored
    wrOp(2, 8'hFF); probe(2, "R10");
    wrOp(3, 8'hFF); probe(3, "R10");
    wrOp(0, 8'h00); probe(0, "R10");
    wrOp(6, 8'hFF); probe(6, "R10"); check("R10", busRdata, 0);
    probe(1, "R10");

    // random phase
    for (int c = 0; c < RAND_CYC; c++) begin
      int op;
      lineSig = $urandom_range(0, 3) == 0;
      if ($urandom_range(0, 7) == 0) rxInfo = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 15) == 0) rxCodeViol = ~rxCodeViol;
      if ($urandom_range(0, 3) == 0) sqRxCode = 4'($urandom_range(0, 15));
      mfStrobe = (c % MF_CYC) == 0;
      op = $urandom_range(0, 5);
      busAddr = 3'($urandom_range(0, 7));
      busWdata = 8'($urandom_range(0, 255));
      if (op < 2) busRd = 1;
      else if (op == 2) busWr = 1;
      doCycle();
    end

    finish();
  end

endmodule